// File: doc/BRIEF.md
# Flash Program/Erase Control Interlock

This block is the register-level safety gate that stands between software and a flash array's program and erase machinery. Software opens a write-enable, arms a setup stage for either programming or erasing, and only then raises the matching program or erase command. A separate block-select field picks the one erase block that a command targets. Any request made out of order, or a drop into a low-power state while a command is active, latches an error that locks every command output low until a full reset or hardware standby.

Software reaches the block over a byte-wide register bus with a combinational read path and edge-triggered writes. A three-bit power-mode input tells the block which operating state the chip is in, so that the block can drop armed state on entry into standby and sleep-type modes. The outputs go straight to the flash array's pulse and block-decode logic, which is outside this block.

Top module: `flash_pe_interlock`

## Requirements
- R1: After reset, and on any clock edge where mode_i is 1 (hardware standby), every register bit clears, including the write-enable and the error flag, and all four registers read 0x00; writes in that cycle are ignored. Mode codes: 0 run, 1 hardware standby, 2 software standby, 3 sub-active, 4 sub-sleep, 5 watch; 6 and 7 act as run.
- R2: Register map: address 0 is the control register (bit 0 write-enable, bit 1 program, bit 2 erase); address 1 is the setup register (bit 0 erase-setup, bit 1 program-setup, bit 6 error flag); address 2 holds block selects 0 to 7 and address 3 holds block selects 8 to 15 (bit n of address 3 is block 8+n). rdata_o shows the addressed register in the same cycle; writes land on the rising edge where we_i is 1.
- R3: Writes to the setup bits take effect only while the write-enable is already 1; writing 0 cancels the setup stage, and cancelling a setup bit also drops its program or erase command.
- R4: A control write with bit 0 set raises program only if program-setup is already 1, and erase only if erase-setup is already 1; a control write with bit 0 clear never raises either.
- R5: The error flag sets when a control write with bit 0 set asks for program without program-setup, erase without erase-setup, or both at once. It is read-only, it forces program, erase and both setup bits to 0 and blocks writes to them while set, and only reset or hardware standby clears it.
- R6: On any edge where mode_i is 2, 3, 4 or 5, both setup bits, program, erase and all block selects clear; the write-enable keeps its value, and writes to the cleared fields in that cycle are ignored.
- R7: Entering a mode of R6 while program or erase is 1 sets the error flag.
- R8: Clearing the write-enable clears both setup bits, program, erase and all block selects in the same edge.
- R9: A block-select write that would leave more than one bit set across addresses 2 and 3 together clears all sixteen bits.
- R10: Control bits 7 to 3 and setup bits 7, 5, 4, 3 and 2 read as 0 and ignore writes; the error flag bit is also not writable.
- R11: Block-select writes are ignored while the write-enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 3 | Power mode code (R1) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data of the addressed register |
| erase_setup_o | output | 1 | Erase setup stage armed |
| prog_setup_o | output | 1 | Program setup stage armed |
| erase_o | output | 1 | Erase command |
| prog_o | output | 1 | Program command |
| blk_sel_o | output | 16 | Erase block select, at most one bit set |
| err_lock_o | output | 1 | Error-protection flag |

## Verification
The bound checker watches on every cycle that an active error leaves all command and setup outputs low, that each command is only high beside its setup bit, that the block select never holds two bits, that a low-power mode empties the armed state, that the error flag survives everything except hardware standby, and that a closed write-enable leaves nothing armed. What the checker cannot see is which register write caused a state, so the bench's scenarios show the write-ordering gates, the precise error triggers, the combinational read map with its reserved bits, and the self-clearing of the block select when a second bit arrives through the other address.

// File: rtl/flash_ilk_pkg.sv
package flash_ilk_pkg;

  typedef enum logic [2:0] {
    PM_RUN     = 3'd0,
    PM_HW_STBY = 3'd1,
    PM_SW_STBY = 3'd2,
    PM_SUB_ACT = 3'd3,
    PM_SUB_SLP = 3'd4,
    PM_WATCH   = 3'd5
  } pwr_mode_e;

  // register addresses
  localparam int unsigned CTRL_ADR     = 0;
  localparam int unsigned SETUP_ADR    = 1;
  localparam int unsigned BLK_BASE_ADR = 2;

  // control register bit positions
  localparam int unsigned CTRL_WEN_BIT = 0;
  localparam int unsigned CTRL_PRG_BIT = 1;
  localparam int unsigned CTRL_ERS_BIT = 2;

  // setup register bit positions
  localparam int unsigned SET_ESU_BIT = 0;
  localparam int unsigned SET_PSU_BIT = 1;
  localparam int unsigned SET_ERR_BIT = 6;

  typedef struct packed {
    logic hw_clr;   // hardware standby: full clear
    logic lp_clr;   // low-power entry: drop armed state
  } pwr_evt_t;

endpackage

// File: rtl/ilk_mode_decode.sv
module ilk_mode_decode
  import flash_ilk_pkg::*;
(
  input  logic [2:0] mode_i,
  output pwr_evt_t   evt_o
);

  always_comb begin
    evt_o = '0;
    unique case (mode_i)
      PM_HW_STBY: evt_o.hw_clr = 1'b1;
      PM_SW_STBY,
      PM_SUB_ACT,
      PM_SUB_SLP,
      PM_WATCH:   evt_o.lp_clr = 1'b1;
      default:    evt_o = '0;
    endcase
  end

endmodule

// File: rtl/ilk_ctrl_core.sv
module ilk_ctrl_core
  import flash_ilk_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pwr_evt_t          evt_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_setup_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wen_q_o,
  output logic              wen_nx_o,
  output logic              prog_q_o,
  output logic              ers_q_o,
  output logic              esu_q_o,
  output logic              psu_q_o,
  output logic              err_q_o
);

  logic wen_q, prog_q, ers_q, esu_q, psu_q, err_q;
  logic wen_d, prog_d, ers_d, esu_d, psu_d, err_d;
  logic req_p, req_e;
  logic upd;

  assign req_p = wdata_i[CTRL_PRG_BIT];
  assign req_e = wdata_i[CTRL_ERS_BIT];

  // next-state process
  always_comb begin
    wen_d  = wen_q;
    prog_d = prog_q;
    ers_d  = ers_q;
    esu_d  = esu_q;
    psu_d  = psu_q;
    err_d  = err_q;

    if (wr_ctrl_i) begin
      wen_d = wdata_i[CTRL_WEN_BIT];
    end

    if (!evt_i.lp_clr && !err_q) begin
      if (wr_setup_i && wen_q) begin
        esu_d = wdata_i[SET_ESU_BIT];
        psu_d = wdata_i[SET_PSU_BIT];
      end
      if (wr_ctrl_i && wdata_i[CTRL_WEN_BIT]) begin
        if ((req_p && req_e) || (req_p && !psu_q) || (req_e && !esu_q)) begin
          err_d  = 1'b1;
          prog_d = 1'b0;
          ers_d  = 1'b0;
        end else begin
          prog_d = req_p;
          ers_d  = req_e;
        end
      end
    end

    if (evt_i.lp_clr) begin
      if (prog_q || ers_q) begin
        err_d = 1'b1;
      end
      esu_d  = 1'b0;
      psu_d  = 1'b0;
      prog_d = 1'b0;
      ers_d  = 1'b0;
    end

    // a closed write-enable leaves nothing armed
    if (!wen_d) begin
      esu_d  = 1'b0;
      psu_d  = 1'b0;
      prog_d = 1'b0;
      ers_d  = 1'b0;
    end

    // a command cannot outlive its setup stage
    prog_d = prog_d & psu_d;
    ers_d  = ers_d & esu_d;

    if (err_d) begin
      esu_d  = 1'b0;
      psu_d  = 1'b0;
      prog_d = 1'b0;
      ers_d  = 1'b0;
    end

    if (evt_i.hw_clr) begin
      wen_d  = 1'b0;
      prog_d = 1'b0;
      ers_d  = 1'b0;
      esu_d  = 1'b0;
      psu_d  = 1'b0;
      err_d  = 1'b0;
    end
  end

  assign upd = (wen_d  != wen_q)  || (prog_d != prog_q) || (ers_d != ers_q) ||
               (esu_d  != esu_q)  || (psu_d  != psu_q)  || (err_d != err_q);

  // register process with explicit clock enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q  <= 1'b0;
      prog_q <= 1'b0;
      ers_q  <= 1'b0;
      esu_q  <= 1'b0;
      psu_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (upd) begin
      wen_q  <= wen_d;
      prog_q <= prog_d;
      ers_q  <= ers_d;
      esu_q  <= esu_d;
      psu_q  <= psu_d;
      err_q  <= err_d;
    end
  end

  assign wen_q_o  = wen_q;
  assign wen_nx_o = wen_d;
  assign prog_q_o = prog_q;
  assign ers_q_o  = ers_q;
  assign esu_q_o  = esu_q;
  assign psu_q_o  = psu_q;
  assign err_q_o  = err_q;

endmodule

// File: rtl/ilk_blk_sel.sv
module ilk_blk_sel #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_REG  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic [N_REG-1:0]          wr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [N_REG*DATA_W-1:0]   sel_o
);

  localparam int unsigned TOT_W = N_REG * DATA_W;
  localparam int unsigned CNT_W = $clog2(TOT_W + 1);

  logic [TOT_W-1:0] sel_q;
  logic [TOT_W-1:0] cand;
  logic [TOT_W-1:0] sel_d;
  logic [CNT_W-1:0] ones;
  logic             multi;

  // candidate value with the written byte merged in
  always_comb begin
    cand = sel_q;
    for (int i = 0; i < int'(N_REG); i++) begin
      if (wr_i[i]) begin
        cand[i*DATA_W +: DATA_W] = wdata_i;
      end
    end
  end

  assign ones  = CNT_W'($countones(cand));
  assign multi = (ones > CNT_W'(1));

  always_comb begin
    if (clr_i || multi) begin
      sel_d = '0;
    end else begin
      sel_d = cand;
    end
  end

  // one byte register per address, each with its own clock enable
  for (genvar g = 0; g < int'(N_REG); g++) begin : g_byte
    logic en;
    assign en = (sel_d[g*DATA_W +: DATA_W] != sel_q[g*DATA_W +: DATA_W]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q[g*DATA_W +: DATA_W] <= '0;
      end else if (en) begin
        sel_q[g*DATA_W +: DATA_W] <= sel_d[g*DATA_W +: DATA_W];
      end
    end
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/ilk_rd_mux.sv
module ilk_rd_mux
  import flash_ilk_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_REG  = 2,
  parameter int unsigned ADDR_W = 2
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    wen_i,
  input  logic                    prog_i,
  input  logic                    ers_i,
  input  logic                    esu_i,
  input  logic                    psu_i,
  input  logic                    err_i,
  input  logic [N_REG*DATA_W-1:0] blk_i,
  output logic [DATA_W-1:0]       rdata_o
);

  logic [DATA_W-1:0] ctrl_img;
  logic [DATA_W-1:0] setup_img;

  always_comb begin
    ctrl_img               = '0;
    ctrl_img[CTRL_WEN_BIT] = wen_i;
    ctrl_img[CTRL_PRG_BIT] = prog_i;
    ctrl_img[CTRL_ERS_BIT] = ers_i;
    setup_img              = '0;
    setup_img[SET_ESU_BIT] = esu_i;
    setup_img[SET_PSU_BIT] = psu_i;
    setup_img[SET_ERR_BIT] = err_i;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_ADR)) begin
      rdata_o = ctrl_img;
    end else if (addr_i == ADDR_W'(SETUP_ADR)) begin
      rdata_o = setup_img;
    end
    for (int i = 0; i < int'(N_REG); i++) begin
      if (addr_i == ADDR_W'(BLK_BASE_ADR + i)) begin
        rdata_o = blk_i[i*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/flash_pe_interlock.sv
module flash_pe_interlock
  import flash_ilk_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_BLK_REG = 2,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [2:0]                  mode_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic                        we_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        erase_setup_o,
  output logic                        prog_setup_o,
  output logic                        erase_o,
  output logic                        prog_o,
  output logic [N_BLK_REG*DATA_W-1:0] blk_sel_o,
  output logic                        err_lock_o
);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic rst_n_s;
  assign rst_n_s = rst_sync_q;

  pwr_evt_t evt;
  ilk_mode_decode u_mode (
    .mode_i (mode_i),
    .evt_o  (evt)
  );

  logic wr_ctrl, wr_setup;
  assign wr_ctrl  = we_i && (addr_i == ADDR_W'(CTRL_ADR));
  assign wr_setup = we_i && (addr_i == ADDR_W'(SETUP_ADR));

  logic wen_q, wen_nx, prog_q, ers_q, esu_q, psu_q, err_q;

  ilk_ctrl_core #(.DATA_W(DATA_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .evt_i      (evt),
    .wr_ctrl_i  (wr_ctrl),
    .wr_setup_i (wr_setup),
    .wdata_i    (wdata_i),
    .wen_q_o    (wen_q),
    .wen_nx_o   (wen_nx),
    .prog_q_o   (prog_q),
    .ers_q_o    (ers_q),
    .esu_q_o    (esu_q),
    .psu_q_o    (psu_q),
    .err_q_o    (err_q)
  );

  // per-address block-select write strobes, open only with write-enable set
  logic [N_BLK_REG-1:0] wr_blk;
  for (genvar g = 0; g < int'(N_BLK_REG); g++) begin : g_blk_wr
    assign wr_blk[g] = we_i && wen_q && (addr_i == ADDR_W'(BLK_BASE_ADR + g));
  end

  logic blk_clr;
  assign blk_clr = evt.hw_clr || evt.lp_clr || !wen_nx;

  logic [N_BLK_REG*DATA_W-1:0] blk_q;
  ilk_blk_sel #(.DATA_W(DATA_W), .N_REG(N_BLK_REG)) u_blk (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .clr_i   (blk_clr),
    .wr_i    (wr_blk),
    .wdata_i (wdata_i),
    .sel_o   (blk_q)
  );

  ilk_rd_mux #(.DATA_W(DATA_W), .N_REG(N_BLK_REG), .ADDR_W(ADDR_W)) u_rd (
    .addr_i  (addr_i),
    .wen_i   (wen_q),
    .prog_i  (prog_q),
    .ers_i   (ers_q),
    .esu_i   (esu_q),
    .psu_i   (psu_q),
    .err_i   (err_q),
    .blk_i   (blk_q),
    .rdata_o (rdata_o)
  );

  assign erase_setup_o = esu_q;
  assign prog_setup_o  = psu_q;
  assign erase_o       = ers_q;
  assign prog_o        = prog_q;
  assign blk_sel_o     = blk_q;
  assign err_lock_o    = err_q;

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker #(
  parameter int unsigned BLK_W = 16
) (
  input logic             clk_i,
  input logic             rst_n_s,
  input logic [2:0]       mode_i,
  input logic             wen_q,
  input logic             erase_setup_o,
  input logic             prog_setup_o,
  input logic             erase_o,
  input logic             prog_o,
  input logic [BLK_W-1:0] blk_sel_o,
  input logic             err_lock_o
);

  logic lp_mode;
  assign lp_mode = (mode_i >= 3'd2) && (mode_i <= 3'd5);

  // R5: active error holds every command and setup output low
  a_r5_err_forces_low: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    err_lock_o |-> !(prog_o || erase_o || prog_setup_o || erase_setup_o));

  // R5: error survives everything except hardware standby
  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (err_lock_o && mode_i != 3'd1) |=> err_lock_o);

  // R4: commands only beside their setup bit, never both
  a_r4_prog_needs_setup: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    prog_o |-> prog_setup_o);
  a_r4_erase_needs_setup: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    erase_o |-> erase_setup_o);
  a_r4_not_both: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !(prog_o && erase_o));

  // R9: block select is never multi-hot
  a_r9_blk_onehot: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $onehot0(blk_sel_o));

  // R6: low-power mode leaves nothing armed
  a_r6_lp_clears: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    lp_mode |=> !(prog_setup_o || erase_setup_o || prog_o || erase_o) && (blk_sel_o == '0));

  // R7: low-power entry during a command latches the error
  a_r7_lp_active_err: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (lp_mode && (prog_o || erase_o)) |=> err_lock_o);

  // R1: hardware standby clears the error flag
  a_r1_hw_clears: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (mode_i == 3'd1) |=> !err_lock_o && !wen_q);

  // R8: closed write-enable leaves nothing armed
  a_r8_wen_closed: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !wen_q |-> !(prog_setup_o || erase_setup_o) && (blk_sel_o == '0));

  // R3: a setup bit only rises with write-enable open
  a_r3_setup_rise: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ($rose(prog_setup_o) || $rose(erase_setup_o)) |-> wen_q);

endmodule

bind flash_pe_interlock ilk_checker #(.BLK_W(N_BLK_REG*DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_n_s       (rst_n_s),
  .mode_i        (mode_i),
  .wen_q         (wen_q),
  .erase_setup_o (erase_setup_o),
  .prog_setup_o  (prog_setup_o),
  .erase_o       (erase_o),
  .prog_o        (prog_o),
  .blk_sel_o     (blk_sel_o),
  .err_lock_o    (err_lock_o)
);

// File: tb/flash_pe_interlock_tb_top.sv
module flash_pe_interlock_tb_top;

  logic        clk;
  logic        rst_n;
  logic [2:0]  mode;
  logic [1:0]  addr;
  logic [7:0]  wdata;
  logic        we;
  logic [7:0]  rdata;
  logic        esu, psu, ers, prg, err;
  logic [15:0] blk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  flash_pe_interlock dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .mode_i        (mode),
    .addr_i        (addr),
    .wdata_i       (wdata),
    .we_i          (we),
    .rdata_o       (rdata),
    .erase_setup_o (esu),
    .prog_setup_o  (psu),
    .erase_o       (ers),
    .prog_o        (prg),
    .blk_sel_o     (blk),
    .err_lock_o    (err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode = m;
    @(negedge clk);
    mode = 3'd0;
  endtask

  task automatic hw_clear();
    set_mode(3'd1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1", $sformatf("reset read addr %0d", a), v, 0);
    end
    chk("R1", "reset outputs", {esu, psu, ers, prg, err, blk}, 0);
  endtask

  task automatic t_setup_gate();
    logic [7:0] v;
    hw_clear();
    wr(2'd1, 8'h03);
    rd(2'd1, v); chk("R3", "setup write with enable closed", v, 8'h00);
    wr(2'd0, 8'h01);
    rd(2'd0, v); chk("R2", "control read wen", v, 8'h01);
    wr(2'd1, 8'h01);
    chk("R3", "erase-setup armed", {esu, psu}, 2'b10);
    wr(2'd1, 8'h02);
    chk("R3", "erase-setup cancelled, program-setup armed", {esu, psu}, 2'b01);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R10", "setup reserved and error bits", v, 8'h03);
    chk("R5", "error not writable", err, 1'b0);
    wr(2'd0, 8'hF9);
    rd(2'd0, v); chk("R10", "control reserved bits", v, 8'h01);
  endtask

  task automatic t_commands();
    logic [7:0] v;
    hw_clear();
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h03);
    chk("R4", "program after setup", {prg, ers, err}, 3'b100);
    rd(2'd0, v); chk("R2", "control read program", v, 8'h03);
    wr(2'd1, 8'h00);
    chk("R3", "cancel setup drops program", {prg, psu}, 2'b00);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h05);
    chk("R4", "erase after setup", {prg, ers, err}, 3'b010);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h06);
    chk("R4", "no command with wen bit clear", {prg, ers, err}, 3'b000);
  endtask

  task automatic t_errors();
    logic [7:0] v;
    hw_clear();
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h03);
    chk("R5", "program without setup sets error", {prg, err}, 2'b01);
    rd(2'd1, v); chk("R5", "error read", v, 8'h40);
    wr(2'd1, 8'h03);
    rd(2'd1, v); chk("R5", "setup blocked under error", v, 8'h40);
    set_mode(3'd2);
    wr(2'd0, 8'h00);
    chk("R5", "error survives low power and wen clear", err, 1'b1);
    hw_clear();
    rd(2'd1, v); chk("R1", "hardware standby clears error", v, 8'h00);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h07);
    chk("R5", "both commands: error, all forced low",
        {err, prg, ers, esu, psu}, 5'b10000);
    hw_clear();
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h05);
    chk("R5", "erase without its setup", {err, ers}, 2'b10);
    hw_clear();
  endtask

  task automatic t_low_power();
    logic [7:0] v;
    for (int m = 2; m <= 5; m++) begin
      hw_clear();
      wr(2'd0, 8'h01);
      wr(2'd1, 8'h01);
      wr(2'd2, 8'h10);
      set_mode(3'(m));
      chk("R6", $sformatf("mode %0d clears armed state", m), {esu, psu, blk}, 0);
      rd(2'd0, v); chk("R6", $sformatf("mode %0d keeps wen", m), v, 8'h01);
      chk("R6", "no error when idle", err, 1'b0);
    end
    hw_clear();
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h03);
    set_mode(3'd5);
    chk("R7", "low power during program", {err, prg}, 2'b10);
    hw_clear();
  endtask

  task automatic t_wen_clear();
    hw_clear();
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h03);
    wr(2'd3, 8'h20);
    chk("R8", "armed before clear", {esu, psu, blk}, {2'b11, 16'h2000});
    wr(2'd0, 8'h00);
    chk("R8", "wen clear empties state", {esu, psu, blk}, 0);
    wr(2'd2, 8'h01);
    chk("R11", "block write with wen closed", blk, 16'h0000);
  endtask

  task automatic t_blk();
    logic [7:0] v;
    hw_clear();
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h04);
    chk("R9", "single low block", blk, 16'h0004);
    rd(2'd2, v); chk("R2", "low block read", v, 8'h04);
    wr(2'd3, 8'h01);
    chk("R9", "second bit across registers clears all", blk, 16'h0000);
    wr(2'd3, 8'h80);
    chk("R9", "single high block", blk, 16'h8000);
    rd(2'd3, v); chk("R2", "high block read", v, 8'h80);
    wr(2'd2, 8'h03);
    chk("R9", "multi in low with high set", blk, 16'h0000);
    wr(2'd2, 8'h06);
    chk("R9", "two bits in one register", blk, 16'h0000);
    wr(2'd3, 8'h10);
    wr(2'd3, 8'h00);
    chk("R9", "writing zero deselects", blk, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; mode = 3'd0; addr = '0; wdata = '0; we = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_setup_gate();
    t_commands();
    t_errors();
    t_low_power();
    t_wen_clear();
    t_blk();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule